// File: doc/BRIEF.md
# Event-to-Interrupt Map Command Executor

This block carries out one of two mapping commands fetched from an in-memory command queue. Both commands bind an event of a device to an interrupt and a target collection by writing a translation entry into that device's translation table. The explicit form names the interrupt ID in the command. The self form binds the event to an interrupt ID equal to its own event number. The queue owner pulses `cmd_start` with the first command doubleword and the command's byte offset in the queue. The executor then fetches the remaining doublewords and looks up the device entry. It checks the fields against the configured limits and either writes the new entry or drops the command. It finishes with a one-cycle `cmd_done`.

All memory traffic goes through a single request/acknowledge port that moves 64 bits at a time. A bus error on any access ends the command at once, and `cmd_err` is raised alongside `cmd_done`. Moving the queue pointers is left to the surrounding logic.

Top module: `map_cmd_exec`

## Requirements
- R1: Command fields: opcode is word0[7:0] (0x0A explicit form, 0x0B self form), device ID is word0[63:32], event ID is word1[31:0], explicit interrupt ID is word1[63:32], collection ID is word2[15:0].
- R2: Word1 is read at queue base + offset + 8 and word2 at queue base + offset + 16. The device entry is read next at device base + device ID × 8. Each access keeps `mem_req`, address, write flag and data steady until `mem_ack`.
- R3: Device entry layout: bit 0 valid, bits 5:1 size, bits 45:6 the translation table base shifted right by 8.
- R4: An accepted command writes two doublewords. The low word goes to table base + event × 16, with bit 0 = 1, bit 1 = 1, bits 25:2 = interrupt ID[23:0] and bits 35:26 = 1023. The high word goes to the next doubleword and holds the collection ID in bits 15:0, zeros elsewhere.
- R5: In the self form the written interrupt ID is the event ID, and word1[63:32] has no effect. No interrupt ID range check is applied.
- R6: The explicit form drops the command unless 8192 ≤ interrupt ID ≤ 2^(cfg_id_bits+1).
- R7: A device ID above `cfg_max_dev` or a collection ID above `cfg_max_coll` drops the command. An out-of-range device ID also skips the device entry read.
- R8: An invalid device entry, or an event ID above 2^(size+1), drops the command.
- R9: A dropped command ends with `cmd_done` high, `cmd_err` low and no memory write.
- R10: A memory error on any access ends the command with `cmd_done` and `cmd_err` both high, and no further access is made.
- R11: `cmd_done` is a one-cycle pulse with `mem_req` low in that cycle. `cmd_start` is ignored while a command is in progress. An unknown opcode ends at once with no memory access and no error.
- R12: After reset `mem_req`, `cmd_done` and `cmd_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Begin a command (taken only when idle) |
| cmd_word0 | input | 64 | First command doubleword |
| cmd_offset | input | OFF_W | Byte offset of the command in the queue |
| cfg_queue_base | input | ADDR_W | Queue base address |
| cfg_dev_base | input | ADDR_W | Device table base address |
| cfg_max_dev | input | DEV_W | Largest legal device ID |
| cfg_max_coll | input | COLL_W | Largest legal collection ID |
| cfg_id_bits | input | 5 | Interrupt ID bits minus one |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 64 | Read data, valid with ack |
| mem_err | input | 1 | Access failed, valid with ack |
| cmd_done | output | 1 | Command finished (pulse) |
| cmd_err | output | 1 | Command ended by memory error |

## Verification
The hardest cases to reach are the failures midway through a command: a bus error on the second queue read, or on the first of the two entry writes. The stimulus reaches them through the bench's memory model, which can be armed to return an error when one chosen address is acknowledged. Every other access is answered normally, so the executor has already committed to the sequence when the fault lands. The inclusive edges of each limit are driven from the vector table as matched pairs on both sides of the limit. Each pair is judged by counting writes and reads at the memory port.

// File: rtl/map_cmd_pkg.sv
package map_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_W1,
        ST_RD_W2,
        ST_RD_DEV,
        ST_CHECK,
        ST_WR_LO,
        ST_WR_HI
    } mc_state_e;

    localparam logic [7:0] OPC_MAP_EXPLICIT = 8'h0A;
    localparam logic [7:0] OPC_MAP_SELF     = 8'h0B;

    localparam int unsigned LPI_FLOOR  = 8192;
    localparam int unsigned SPUR_VALUE = 1023;

endpackage

// File: rtl/map_cmd_fields.sv
module map_cmd_fields #(
    parameter int DEV_W  = 32,
    parameter int EVT_W  = 32,
    parameter int COLL_W = 16
) (
    input  logic [63:0]       word0,
    input  logic [63:0]       word1,
    input  logic [63:0]       word2,
    output logic [7:0]        opcode,
    output logic [DEV_W-1:0]  dev_id,
    output logic [EVT_W-1:0]  evt_id,
    output logic [31:0]       int_id,
    output logic [COLL_W-1:0] coll_id
);
    always_comb begin
        opcode  = word0[7:0];
        dev_id  = word0[32 +: DEV_W];
        evt_id  = word1[EVT_W-1:0];
        int_id  = word1[63:32];
        coll_id = word2[COLL_W-1:0];
    end
endmodule

// File: rtl/map_cmd_limits.sv
module map_cmd_limits #(
    parameter int DEV_W  = 32,
    parameter int EVT_W  = 32,
    parameter int COLL_W = 16
) (
    input  logic              self_form,
    input  logic [DEV_W-1:0]  dev_id,
    input  logic [EVT_W-1:0]  evt_id,
    input  logic [31:0]       int_id,
    input  logic [COLL_W-1:0] coll_id,
    input  logic              dev_valid,
    input  logic [4:0]        dev_size,
    input  logic [DEV_W-1:0]  max_dev,
    input  logic [COLL_W-1:0] max_coll,
    input  logic [4:0]        id_bits,
    output logic              dev_in_range,
    output logic              accept
);
    import map_cmd_pkg::*;

    localparam int LIM_W = 34;

    logic [LIM_W-1:0] evt_limit;
    logic [LIM_W-1:0] id_limit;
    logic             evt_ok;
    logic             id_ok;
    logic             coll_ok;

    always_comb begin
        evt_limit    = LIM_W'(1) << ({1'b0, dev_size} + 6'd1);
        id_limit     = LIM_W'(1) << ({1'b0, id_bits} + 6'd1);
        dev_in_range = (dev_id <= max_dev);
        coll_ok      = (coll_id <= max_coll);
        evt_ok       = (LIM_W'(evt_id) <= evt_limit);
        id_ok        = self_form ||
                       ((LIM_W'(int_id) >= LIM_W'(LPI_FLOOR)) &&
                        (LIM_W'(int_id) <= id_limit));
        accept       = dev_in_range && coll_ok && dev_valid && evt_ok && id_ok;
    end
endmodule

// File: rtl/map_cmd_entry.sv
module map_cmd_entry #(
    parameter int ADDR_W     = 48,
    parameter int EVT_W      = 32,
    parameter int COLL_W     = 16,
    parameter int ID_FIELD_W = 24
) (
    input  logic              self_form,
    input  logic [EVT_W-1:0]  evt_id,
    input  logic [31:0]       int_id,
    input  logic [COLL_W-1:0] coll_id,
    input  logic [63:0]       dev_entry,
    output logic [ADDR_W-1:0] lo_addr,
    output logic [ADDR_W-1:0] hi_addr,
    output logic [63:0]       lo_data,
    output logic [63:0]       hi_data
);
    import map_cmd_pkg::*;

    localparam int BASE_HI  = ADDR_W - 3;
    localparam int SPUR_LSB = 2 + ID_FIELD_W;

    logic [ADDR_W-1:0] table_base;
    logic [31:0]       chosen_id;

    always_comb begin
        table_base = {dev_entry[BASE_HI:6], 8'h00};
        lo_addr    = table_base + {{(ADDR_W-EVT_W-4){1'b0}}, evt_id, 4'h0};
        hi_addr    = lo_addr + ADDR_W'(8);
        chosen_id  = self_form ? 32'(evt_id) : int_id;
        lo_data    = '0;
        lo_data[0] = 1'b1;
        lo_data[1] = 1'b1;
        lo_data[2 +: ID_FIELD_W] = chosen_id[ID_FIELD_W-1:0];
        lo_data[SPUR_LSB +: 10]  = 10'(SPUR_VALUE);
        hi_data    = {{(64-COLL_W){1'b0}}, coll_id};
    end
endmodule

// File: rtl/map_cmd_exec.sv
module map_cmd_exec #(
    parameter int ADDR_W     = 48,
    parameter int OFF_W      = 20,
    parameter int DEV_W      = 32,
    parameter int EVT_W      = 32,
    parameter int COLL_W     = 16,
    parameter int ID_FIELD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [63:0]       cmd_word0,
    input  logic [OFF_W-1:0]  cmd_offset,
    input  logic [ADDR_W-1:0] cfg_queue_base,
    input  logic [ADDR_W-1:0] cfg_dev_base,
    input  logic [DEV_W-1:0]  cfg_max_dev,
    input  logic [COLL_W-1:0] cfg_max_coll,
    input  logic [4:0]        cfg_id_bits,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [63:0]       mem_rdata,
    input  logic              mem_err,
    output logic              cmd_done,
    output logic              cmd_err
);
    import map_cmd_pkg::*;

    localparam int DEV_PAD = ADDR_W - DEV_W - 3;
    localparam int OFF_PAD = ADDR_W - OFF_W;

    typedef struct packed {
        mc_state_e         st;
        logic [7:0]        opc;
        logic [DEV_W-1:0]  dev;
        logic [OFF_W-1:0]  off;
        logic [63:0]       w1;
        logic [COLL_W-1:0] coll;
        logic [63:0]       dte;
        logic              req;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [63:0]       wdata;
        logic              done;
        logic              err;
    } regs_t;

    regs_t r_q, r_d;

    logic [7:0]        start_opc;
    logic [DEV_W-1:0]  start_dev;
    logic [EVT_W-1:0]  evt_id;
    logic [31:0]       int_id;
    logic [COLL_W-1:0] rd_coll;
    logic              self_form;
    logic              dev_in_range;
    logic              accept;
    logic [ADDR_W-1:0] lo_addr;
    logic [ADDR_W-1:0] hi_addr;
    logic [63:0]       lo_data;
    logic [63:0]       hi_data;
    logic [ADDR_W-1:0] q_addr;

    map_cmd_fields #(.DEV_W(DEV_W), .EVT_W(EVT_W), .COLL_W(COLL_W)) u_fields (
        .word0   (cmd_word0),
        .word1   (r_q.w1),
        .word2   (mem_rdata),
        .opcode  (start_opc),
        .dev_id  (start_dev),
        .evt_id  (evt_id),
        .int_id  (int_id),
        .coll_id (rd_coll)
    );

    assign self_form = (r_q.opc == OPC_MAP_SELF);

    map_cmd_limits #(.DEV_W(DEV_W), .EVT_W(EVT_W), .COLL_W(COLL_W)) u_limits (
        .self_form    (self_form),
        .dev_id       (r_q.dev),
        .evt_id       (evt_id),
        .int_id       (int_id),
        .coll_id      (r_q.coll),
        .dev_valid    (r_q.dte[0]),
        .dev_size     (r_q.dte[5:1]),
        .max_dev      (cfg_max_dev),
        .max_coll     (cfg_max_coll),
        .id_bits      (cfg_id_bits),
        .dev_in_range (dev_in_range),
        .accept       (accept)
    );

    map_cmd_entry #(
        .ADDR_W(ADDR_W), .EVT_W(EVT_W), .COLL_W(COLL_W), .ID_FIELD_W(ID_FIELD_W)
    ) u_entry (
        .self_form (self_form),
        .evt_id    (evt_id),
        .int_id    (int_id),
        .coll_id   (r_q.coll),
        .dev_entry (r_q.dte),
        .lo_addr   (lo_addr),
        .hi_addr   (hi_addr),
        .lo_data   (lo_data),
        .hi_data   (hi_data)
    );

    assign q_addr = cfg_queue_base + {{OFF_PAD{1'b0}}, r_q.off};

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (cmd_start) begin
                    r_d.opc = start_opc;
                    r_d.dev = start_dev;
                    r_d.off = cmd_offset;
                    if (start_opc == OPC_MAP_EXPLICIT || start_opc == OPC_MAP_SELF) begin
                        r_d.st   = ST_RD_W1;
                        r_d.req  = 1'b1;
                        r_d.we   = 1'b0;
                        r_d.addr = cfg_queue_base + {{OFF_PAD{1'b0}}, cmd_offset}
                                   + ADDR_W'(8);
                    end else begin
                        r_d.done = 1'b1;
                    end
                end
            end
            ST_RD_W1: begin
                if (mem_ack) begin
                    if (mem_err) begin
                        r_d.st = ST_IDLE; r_d.req = 1'b0;
                        r_d.done = 1'b1;  r_d.err = 1'b1;
                    end else begin
                        r_d.w1   = mem_rdata;
                        r_d.addr = q_addr + ADDR_W'(16);
                        r_d.st   = ST_RD_W2;
                    end
                end
            end
            ST_RD_W2: begin
                if (mem_ack) begin
                    if (mem_err) begin
                        r_d.st = ST_IDLE; r_d.req = 1'b0;
                        r_d.done = 1'b1;  r_d.err = 1'b1;
                    end else begin
                        r_d.coll = rd_coll;
                        if (dev_in_range) begin
                            r_d.addr = cfg_dev_base + {{DEV_PAD{1'b0}}, r_q.dev, 3'b000};
                            r_d.st   = ST_RD_DEV;
                        end else begin
                            r_d.st   = ST_IDLE;
                            r_d.req  = 1'b0;
                            r_d.done = 1'b1;
                        end
                    end
                end
            end
            ST_RD_DEV: begin
                if (mem_ack) begin
                    r_d.req = 1'b0;
                    if (mem_err) begin
                        r_d.st = ST_IDLE;
                        r_d.done = 1'b1; r_d.err = 1'b1;
                    end else begin
                        r_d.dte = mem_rdata;
                        r_d.st  = ST_CHECK;
                    end
                end
            end
            ST_CHECK: begin
                if (accept) begin
                    r_d.st    = ST_WR_LO;
                    r_d.req   = 1'b1;
                    r_d.we    = 1'b1;
                    r_d.addr  = lo_addr;
                    r_d.wdata = lo_data;
                end else begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
            ST_WR_LO: begin
                if (mem_ack) begin
                    if (mem_err) begin
                        r_d.st = ST_IDLE; r_d.req = 1'b0; r_d.we = 1'b0;
                        r_d.done = 1'b1;  r_d.err = 1'b1;
                    end else begin
                        r_d.addr  = hi_addr;
                        r_d.wdata = hi_data;
                        r_d.st    = ST_WR_HI;
                    end
                end
            end
            ST_WR_HI: begin
                if (mem_ack) begin
                    r_d.st   = ST_IDLE;
                    r_d.req  = 1'b0;
                    r_d.we   = 1'b0;
                    r_d.done = 1'b1;
                    r_d.err  = mem_err;
                end
            end
            default: begin
                r_d.st  = ST_IDLE;
                r_d.req = 1'b0;
                r_d.we  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req   = r_q.req;
    assign mem_we    = r_q.we;
    assign mem_addr  = r_q.addr;
    assign mem_wdata = r_q.wdata;
    assign cmd_done  = r_q.done;
    assign cmd_err   = r_q.err;

endmodule

// File: rtl/map_cmd_exec_chk.sv
module map_cmd_exec_chk #(
    parameter int ADDR_W = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [63:0]       mem_wdata,
    input logic              mem_ack,
    input logic              cmd_done,
    input logic              cmd_err
);
    // R2: a pending request holds its address, direction and data
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    // R10: error is only reported together with completion
    p_err_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> cmd_done);

    // R11: completion is a single-cycle pulse
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    // R11: no access is outstanding when the command completes
    p_idle_on_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> !mem_req);

    // R2: a write is never issued without a request
    p_we_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);
endmodule

bind map_cmd_exec map_cmd_exec_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .cmd_done  (cmd_done),
    .cmd_err   (cmd_err)
);

// File: tb/map_cmd_exec_test.sv
module map_cmd_exec_test;
    localparam int ADDR_W = 48;
    localparam int OFF_W  = 20;
    localparam logic [47:0] QBASE = 48'h0000_1000_0000;
    localparam logic [47:0] DBASE = 48'h0000_2000_0000;

    typedef struct packed {
        logic        self_f;
        logic [31:0] dev;
        logic [31:0] evt;
        logic [31:0] iid;
        logic [15:0] coll;
        logic        dv;
        logic [4:0]  sz;
        logic        wr;
    } vec_t;

    // max_dev 100, max_coll 63, id_bits 15 (id limit 65536)
    localparam vec_t VEC [14] = '{
        '{1'b0, 32'd5,   32'd3,  32'd8200,       16'd7,  1'b1, 5'd4, 1'b1}, // R4 explicit
        '{1'b1, 32'd6,   32'd40, 32'hFFFF_FFFF,  16'd2,  1'b1, 5'd7, 1'b1}, // R5 self, iid ignored
        '{1'b0, 32'd5,   32'd1,  32'd8191,       16'd1,  1'b1, 5'd4, 1'b0}, // R6 below floor
        '{1'b0, 32'd5,   32'd1,  32'd8192,       16'd1,  1'b1, 5'd4, 1'b1}, // R6 at floor
        '{1'b0, 32'd5,   32'd2,  32'd65536,      16'd1,  1'b1, 5'd4, 1'b1}, // R6 at ceiling
        '{1'b0, 32'd5,   32'd2,  32'd65537,      16'd1,  1'b1, 5'd4, 1'b0}, // R6 above ceiling
        '{1'b0, 32'd9,   32'd32, 32'd9000,       16'd3,  1'b1, 5'd4, 1'b1}, // R8 event at limit
        '{1'b0, 32'd9,   32'd33, 32'd9000,       16'd3,  1'b1, 5'd4, 1'b0}, // R8 event above limit
        '{1'b0, 32'd9,   32'd1,  32'd9000,       16'd3,  1'b0, 5'd4, 1'b0}, // R8 invalid device entry
        '{1'b0, 32'd100, 32'd1,  32'd9000,       16'd3,  1'b1, 5'd4, 1'b1}, // R7 device at limit
        '{1'b0, 32'd101, 32'd1,  32'd9000,       16'd3,  1'b1, 5'd4, 1'b0}, // R7 device above limit
        '{1'b0, 32'd7,   32'd1,  32'd9000,       16'd63, 1'b1, 5'd4, 1'b1}, // R7 collection at limit
        '{1'b0, 32'd7,   32'd1,  32'd9000,       16'd64, 1'b1, 5'd4, 1'b0}, // R7 collection above limit
        '{1'b1, 32'd7,   32'd33, 32'd0,          16'd5,  1'b1, 5'd4, 1'b0}  // R5 self, event limit
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 1'b0;
    logic [63:0] cmd_word0 = '0;
    logic [OFF_W-1:0] cmd_offset = '0;
    logic mem_req, mem_we, mem_ack, mem_err, cmd_done, cmd_err;
    logic [ADDR_W-1:0] mem_addr;
    logic [63:0] mem_wdata, mem_rdata;

    int n_checks = 0;
    int n_errors = 0;

    // memory model state
    logic [63:0] t_w1, t_w2, t_dte;
    logic [31:0] t_dev;
    logic [OFF_W-1:0] t_off;
    logic        err_en = 1'b0;
    logic [47:0] err_addr = '0;
    int          rd_cnt, wr_cnt, done_cnt;
    logic [47:0] rd_addr [4];
    logic [47:0] wr_addr [4];
    logic [63:0] wr_data [4];
    logic        last_err;

    always #10 clk = ~clk;

    map_cmd_exec #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_word0(cmd_word0),
        .cmd_offset(cmd_offset), .cfg_queue_base(QBASE), .cfg_dev_base(DBASE),
        .cfg_max_dev(32'd100), .cfg_max_coll(16'd63), .cfg_id_bits(5'd15),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .cmd_done(cmd_done), .cmd_err(cmd_err)
    );

    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else        mem_ack <= mem_req && !mem_ack;
    end

    assign mem_err   = err_en && (mem_addr == err_addr);
    assign mem_rdata = (mem_addr == QBASE + 48'(t_off) + 48'd8)  ? t_w1 :
                       (mem_addr == QBASE + 48'(t_off) + 48'd16) ? t_w2 :
                       (mem_addr == DBASE + {13'd0, t_dev, 3'b000}) ? t_dte :
                       64'hDEAD_BEEF_DEAD_BEEF;

    always @(posedge clk) begin
        if (mem_req && mem_ack) begin
            if (mem_we) begin
                if (wr_cnt < 4) begin
                    wr_addr[wr_cnt] <= mem_addr;
                    wr_data[wr_cnt] <= mem_wdata;
                end
                wr_cnt <= wr_cnt + 1;
            end else begin
                if (rd_cnt < 4) rd_addr[rd_cnt] <= mem_addr;
                rd_cnt <= rd_cnt + 1;
            end
        end
        if (cmd_done) begin
            done_cnt <= done_cnt + 1;
            last_err <= cmd_err;
        end
    end

    task automatic check(input string req, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    task automatic clear_logs();
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0; done_cnt = 0; last_err = 1'b0;
    endtask

    // Sets up the model, pulses start and waits for completion
    task automatic run_cmd(input logic [7:0] opc, input logic [31:0] dev,
                           input logic [31:0] evt, input logic [31:0] iid,
                           input logic [15:0] coll, input logic dv, input logic [4:0] sz,
                           input logic [47:0] itt, input logic [OFF_W-1:0] off);
        clear_logs();
        t_dev = dev; t_off = off;
        t_w1  = {iid, evt};
        t_w2  = {48'hABCD_0000_1234, coll};
        t_dte = {18'h3FFFF, itt[47:8], sz, dv};
        cmd_word0  = {dev, 24'h5A5A5A, opc};
        cmd_offset = off;
        cmd_start  = 1'b1;
        @(negedge clk);
        cmd_start  = 1'b0;
        for (int k = 0; k < 60 && done_cnt == 0; k++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(20ns * 100000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic [47:0] itt;
        logic [63:0] lo;
        logic [31:0] id;
        logic [OFF_W-1:0] off;

        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12", "mem_req in reset", 64'(mem_req), 64'd0);
        check("R12", "cmd_done in reset", 64'(cmd_done), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", "cmd_err after reset", 64'(cmd_err), 64'd0);

        for (int i = 0; i < 14; i++) begin
            itt = 48'h0000_0040_0000 + 48'(i) * 48'h1000;
            off = OFF_W'(i * 32);
            run_cmd(VEC[i].self_f ? 8'h0B : 8'h0A, VEC[i].dev, VEC[i].evt, VEC[i].iid,
                    VEC[i].coll, VEC[i].dv, VEC[i].sz, itt, off);
            check("R11", $sformatf("v%0d done count", i), 64'(done_cnt), 64'd1);
            check("R9", $sformatf("v%0d err", i), 64'(last_err), 64'd0);
            check("R9", $sformatf("v%0d writes", i), 64'(wr_cnt), VEC[i].wr ? 64'd2 : 64'd0);
            // R2 read sequence, R7 device read skipped when out of range
            check("R7", $sformatf("v%0d reads", i), 64'(rd_cnt),
                  (VEC[i].dev > 32'd100) ? 64'd2 : 64'd3);
            check("R2", $sformatf("v%0d word1 addr", i), 64'(rd_addr[0]),
                  64'(QBASE + 48'(off) + 48'd8));
            check("R2", $sformatf("v%0d word2 addr", i), 64'(rd_addr[1]),
                  64'(QBASE + 48'(off) + 48'd16));
            if (VEC[i].dev <= 32'd100)
                check("R2", $sformatf("v%0d device addr", i), 64'(rd_addr[2]),
                      64'(DBASE + 48'(VEC[i].dev) * 48'd8));
            if (VEC[i].wr) begin
                id = VEC[i].self_f ? VEC[i].evt : VEC[i].iid;
                lo = 64'd3 | (64'(id[23:0]) << 2) | (64'd1023 << 26);
                // R3 table base taken from the device entry, R1 fields
                check("R3", $sformatf("v%0d lo addr", i), 64'(wr_addr[0]),
                      64'(itt + 48'(VEC[i].evt) * 48'd16));
                check("R4", $sformatf("v%0d hi addr", i), 64'(wr_addr[1]),
                      64'(itt + 48'(VEC[i].evt) * 48'd16 + 48'd8));
                check(VEC[i].self_f ? "R5" : "R4", $sformatf("v%0d lo data", i),
                      wr_data[0], lo);
                check("R1", $sformatf("v%0d hi data", i), wr_data[1], 64'(VEC[i].coll));
            end
        end

        // R11 unknown opcode: done, no access, no error
        run_cmd(8'h05, 32'd5, 32'd1, 32'd9000, 16'd1, 1'b1, 5'd4, 48'h50_0000, '0);
        check("R11", "unknown opc done", 64'(done_cnt), 64'd1);
        check("R11", "unknown opc accesses", 64'(rd_cnt + wr_cnt), 64'd0);
        check("R11", "unknown opc err", 64'(last_err), 64'd0);

        // R10 error on second queue read
        err_en = 1'b1; err_addr = QBASE + 48'd64 + 48'd16;
        run_cmd(8'h0A, 32'd5, 32'd1, 32'd9000, 16'd1, 1'b1, 5'd4, 48'h50_0000, 20'd64);
        check("R10", "read error flagged", 64'(last_err), 64'd1);
        check("R10", "read error reads", 64'(rd_cnt), 64'd2);
        check("R10", "read error writes", 64'(wr_cnt), 64'd0);

        // R10 error on low entry write
        err_addr = 48'h50_0000 + 48'd16 * 48'd4;
        run_cmd(8'h0A, 32'd5, 32'd4, 32'd9000, 16'd1, 1'b1, 5'd4, 48'h50_0000, 20'd0);
        check("R10", "write error flagged", 64'(last_err), 64'd1);
        check("R10", "write error writes", 64'(wr_cnt), 64'd1);
        check("R10", "write error done", 64'(done_cnt), 64'd1);
        err_en = 1'b0;

        // R11 start while busy is ignored
        clear_logs();
        t_dev = 32'd8; t_off = '0;
        t_w1 = {32'd8300, 32'd2}; t_w2 = 64'd9;
        t_dte = {18'd0, 40'h6000, 5'd4, 1'b1};
        cmd_word0 = {32'd8, 24'd0, 8'h0A}; cmd_offset = '0; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        @(negedge clk);
        cmd_word0 = {32'd50, 24'd0, 8'h0B}; cmd_offset = 20'd512; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        for (int k = 0; k < 60 && done_cnt == 0; k++) @(negedge clk);
        repeat (6) @(negedge clk);
        check("R11", "busy start done count", 64'(done_cnt), 64'd1);
        check("R11", "busy start hi data", wr_data[1], 64'd9);
        check("R11", "busy start lo addr", 64'(wr_addr[0]),
              64'(48'h60_0000 + 48'd32));

        finish_up();
    end
endmodule